// File: doc/BRIEF.md
# Off-State Load Fault Qualifier

This block watches a bridge load while the drivers are switched off and decides whether the load is healthy or faulty. Each output node has a weak bias: one node is pulled up and the other is pulled down. An analog comparator sits on each node and reports whether that node is above its threshold. The block receives these two comparator results as digital flags. From the pair it classifies the load as healthy, shorted to ground, open, or shorted to the supply rail.

A fault only counts once the same classification has held without a break for longer than a programmable filter window. The window is measured in clock cycles. This gives energy stored in the load time to decay before a verdict is reached. The filter restarts on particular edges of the two enable inputs, which mark the moments when the bias conditions change.

The first fault to qualify is captured in a set of sticky flags. While any flag is held, later faults are disregarded. A single-cycle clear pulse empties the flags, and any fault that is still present must then qualify again from the start.

Top module: `offstate_fault_qual`

## Requirements
- R1: Decoding uses the pair {pu_node_hi, pd_node_hi}. The code 2'b10 (pull-up node above its threshold, pull-down node below its threshold) is an open load, reported on open_flag.
- R2: The code 2'b00 (both nodes below their thresholds) is a short to ground, reported on gnd_short_flag.
- R3: The code 2'b11 (both nodes above their thresholds) is a short to the supply, reported on sup_short_flag.
- R4: The code 2'b01 is a healthy load and never sets any flag, however long it lasts.
- R5: Detection runs only while en_a or en_b is high. With both enables low, no flag is set, whatever the node flags show.
- R6: A fault code that is sampled on FILT_CYC+1 consecutive rising edges sets its flag right after the last of those edges, and not earlier. Any change of the decoded code restarts this count.
- R7: The filter count restarts on two kinds of enable edge: both enables were high and now one or both are low, or both were low and now at least one is high. Going from exactly one enable high to both high does not restart the count.
- R8: At most one flag is set at a time. Once a flag is set, no other flag is set and the set flag stays unchanged until a clear.
- R9: A flt_clr pulse sampled at a rising edge clears every flag at that edge and restarts the count. If the fault persists, it sets its flag again FILT_CYC edges after the clear edge.
- R10: fault_any is high exactly when at least one of the three flags is high.
- R11: rst_n low clears all flags at once, without waiting for a clock edge. Release is synchronized to clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_a | input | 1 | First bridge enable |
| en_b | input | 1 | Second bridge enable |
| pu_node_hi | input | 1 | Pulled-up node is above its high threshold |
| pd_node_hi | input | 1 | Pulled-down node is above its low threshold |
| flt_clr | input | 1 | Single-cycle pulse that clears the flags |
| open_flag | output | 1 | Latched open-load fault |
| gnd_short_flag | output | 1 | Latched short-to-ground fault |
| sup_short_flag | output | 1 | Latched short-to-supply fault |
| fault_any | output | 1 | OR of the three latched flags |

## Verification
Two situations are hard to reach from the ports. The first is an enable edge that restarts the filter while detection stays active. The second is the similar-looking edge that must not restart it. To separate them, the stimulus holds a fault partway through the window and then moves the enables either from both high to one high, or from one high to both high. It then samples the flag exactly at the edge where each outcome predicts a different value. A second delicate case is a clear that arrives while the fault is still present. The bench checks that the flag drops at the clear edge and comes back exactly one full window later.

// File: rtl/ofq_pkg.sv
package ofq_pkg;

  // Load classification; encoding equals {pull-up node high, pull-down node high}
  typedef enum logic [1:0] {
    LS_GND    = 2'b00,
    LS_NORMAL = 2'b01,
    LS_OPEN   = 2'b10,
    LS_SUP    = 2'b11
  } load_st_e;

  localparam int unsigned NUM_FLT = 3;

  // Flag slot -> class code: slot 0 ground, slot 1 open, slot 2 supply
  function automatic load_st_e slot_code(input int unsigned slot);
    case (slot)
      0:       slot_code = LS_GND;
      1:       slot_code = LS_OPEN;
      default: slot_code = LS_SUP;
    endcase
  endfunction

endpackage

// File: rtl/ofq_rst_sync.sv
module ofq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ofq_en_watch.sv
module ofq_en_watch (
  input  logic clk,
  input  logic rst_n,
  input  logic en_a,
  input  logic en_b,
  output logic active,
  output logic restart
);

  logic [1:0] en_q;
  logic [1:0] en_d;
  logic       were_both_hi;
  logic       were_both_lo;

  always_comb begin
    en_d         = {en_b, en_a};
    were_both_hi = &en_q;
    were_both_lo = ~|en_q;
    active       = |en_d;
    restart      = (were_both_hi && !(&en_d)) || (were_both_lo && (|en_d));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

endmodule

// File: rtl/ofq_filter.sv
module ofq_filter
  import ofq_pkg::*;
#(
  parameter int unsigned FILT_CYC = 1024
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     restart,
  input  logic     clr,
  input  logic     hold_off,
  input  load_st_e status,
  output logic     qualify
);

  localparam int unsigned CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  load_st_e      status_q;
  logic          run;

  always_comb begin
    run     = active && (status != LS_NORMAL) && (status == status_q)
              && !restart && !clr && !hold_off;
    cnt_d   = run ? cnt_q + 1'b1 : '0;
    qualify = run && (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      status_q <= LS_NORMAL;
    end else begin
      cnt_q    <= cnt_d;
      status_q <= status;
    end
  end

endmodule

// File: rtl/ofq_latch.sv
module ofq_latch
  import ofq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qualify,
  input  logic               clr,
  input  load_st_e           status,
  output logic [NUM_FLT-1:0] flags
);

  logic [NUM_FLT-1:0] flags_d;
  logic               lat_en;

  always_comb begin
    lat_en = clr || qualify;
  end

  for (genvar g = 0; g < NUM_FLT; g++) begin : g_slot
    always_comb begin
      if (clr) flags_d[g] = 1'b0;
      else     flags_d[g] = flags[g] || (qualify && (status == slot_code(g)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[g] <= 1'b0;
      else if (lat_en) flags[g] <= flags_d[g];
    end
  end

endmodule

// File: rtl/offstate_fault_qual.sv
module offstate_fault_qual
  import ofq_pkg::*;
#(
  parameter int unsigned FILT_CYC = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_a,
  input  logic en_b,
  input  logic pu_node_hi,
  input  logic pd_node_hi,
  input  logic flt_clr,
  output logic open_flag,
  output logic gnd_short_flag,
  output logic sup_short_flag,
  output logic fault_any
);

  logic               rst_sync_n;
  logic               active;
  logic               restart;
  logic               qualify;
  logic [NUM_FLT-1:0] flags;
  load_st_e           status;

  assign status = load_st_e'({pu_node_hi, pd_node_hi});

  ofq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ofq_en_watch u_en (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en_a    (en_a),
    .en_b    (en_b),
    .active  (active),
    .restart (restart)
  );

  ofq_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active   (active),
    .restart  (restart),
    .clr      (flt_clr),
    .hold_off (fault_any),
    .status   (status),
    .qualify  (qualify)
  );

  ofq_latch u_lat (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .qualify (qualify),
    .clr     (flt_clr),
    .status  (status),
    .flags   (flags)
  );

  assign gnd_short_flag = flags[0];
  assign open_flag      = flags[1];
  assign sup_short_flag = flags[2];
  assign fault_any      = |flags;

endmodule

// File: rtl/ofq_checker.sv
module ofq_checker (
  input logic clk,
  input logic rst_n,
  input logic en_a,
  input logic en_b,
  input logic pu_node_hi,
  input logic pd_node_hi,
  input logic flt_clr,
  input logic open_flag,
  input logic gnd_short_flag,
  input logic sup_short_flag,
  input logic fault_any
);

  // R8
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({open_flag, gnd_short_flag, sup_short_flag}));

  // R8
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_any && !flt_clr) |=> $stable({open_flag, gnd_short_flag, sup_short_flag}));

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clr |=> !fault_any);

  // R5
  needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_any) |-> $past(en_a || en_b));

  // R1
  open_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open_flag) |-> $past(pu_node_hi && !pd_node_hi));

  // R2
  gnd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnd_short_flag) |-> $past(!pu_node_hi && !pd_node_hi));

  // R3
  sup_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sup_short_flag) |-> $past(pu_node_hi && pd_node_hi));

  // R10
  any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any == (open_flag || gnd_short_flag || sup_short_flag));

endmodule

bind offstate_fault_qual ofq_checker u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .en_a           (en_a),
  .en_b           (en_b),
  .pu_node_hi     (pu_node_hi),
  .pd_node_hi     (pd_node_hi),
  .flt_clr        (flt_clr),
  .open_flag      (open_flag),
  .gnd_short_flag (gnd_short_flag),
  .sup_short_flag (sup_short_flag),
  .fault_any      (fault_any)
);

// File: tb/offstate_fault_qual_tb.sv
module offstate_fault_qual_tb;

  localparam int unsigned FILT = 20;
  localparam time         TCLK = 8ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_a = 1'b1, en_b = 1'b1;
  logic pu_node_hi = 1'b0, pd_node_hi = 1'b1;
  logic flt_clr = 1'b0;
  logic open_flag, gnd_short_flag, sup_short_flag, fault_any;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Vectors are {fault_any, sup, open, gnd}
  localparam logic [3:0] NONE = 4'b0000;
  localparam logic [3:0] GND  = 4'b1001;
  localparam logic [3:0] OPN  = 4'b1010;
  localparam logic [3:0] SUP  = 4'b1100;

  always #(TCLK/2) clk = ~clk;

  offstate_fault_qual #(.FILT_CYC(FILT)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .en_a           (en_a),
    .en_b           (en_b),
    .pu_node_hi     (pu_node_hi),
    .pd_node_hi     (pd_node_hi),
    .flt_clr        (flt_clr),
    .open_flag      (open_flag),
    .gnd_short_flag (gnd_short_flag),
    .sup_short_flag (sup_short_flag),
    .fault_any      (fault_any)
  );

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] exp, input string tag);
    logic [3:0] act;
    act = {fault_any, sup_short_flag, open_flag, gnd_short_flag};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_code(input logic [1:0] code);
    {pu_node_hi, pd_node_hi} = code;
  endtask

  task automatic settle();
    set_code(2'b01);
    en_a = 1'b1; en_b = 1'b1;
    flt_clr = 1'b1;
    edges(1);
    flt_clr = 1'b0;
    edges(2);
  endtask

  task automatic t_reset();
    set_code(2'b10);
    edges(3 * FILT);
    chk(NONE, "R11 held in reset");
    rst_n = 1'b1;
    set_code(2'b01);
    edges(4);
    chk(NONE, "R11 after release");
  endtask

  task automatic t_normal();
    settle();
    edges(3 * FILT);
    chk(NONE, "R4 healthy never flags");
  endtask

  task automatic t_open();
    settle();
    set_code(2'b10);
    edges(FILT);
    chk(NONE, "R6 open before window");
    edges(1);
    chk(OPN, "R1 open latched");
  endtask

  task automatic t_first_come_clear();
    set_code(2'b11);
    edges(3 * FILT);
    chk(OPN, "R8 later supply short ignored");
    flt_clr = 1'b1;
    edges(1);
    flt_clr = 1'b0;
    chk(NONE, "R9 clear empties flags");
    edges(FILT - 1);
    chk(NONE, "R9 requalify not early");
    edges(1);
    chk(SUP, "R3 supply short after clear");
  endtask

  task automatic t_pattern_change();
    settle();
    set_code(2'b00);
    edges(FILT - 2);
    set_code(2'b10);
    edges(FILT);
    chk(NONE, "R6 code change restarts");
    edges(1);
    chk(OPN, "R6 new code latched");
  endtask

  task automatic t_gnd();
    settle();
    set_code(2'b00);
    edges(FILT);
    chk(NONE, "R2 ground before window");
    edges(1);
    chk(GND, "R2 ground latched");
  endtask

  task automatic t_restart();
    settle();
    set_code(2'b00);
    edges(10);
    en_b = 1'b0;
    edges(FILT);
    chk(NONE, "R7 both-high to one-high restarts");
    edges(1);
    chk(GND, "R7 latched after restart");
  endtask

  task automatic t_no_restart();
    settle();
    en_b = 1'b0;
    edges(2);
    set_code(2'b10);
    edges(5);
    en_b = 1'b1;
    edges(FILT - 5);
    chk(NONE, "R7 one-high to both-high before window");
    edges(1);
    chk(OPN, "R7 one-high to both-high does not restart");
  endtask

  task automatic t_inactive();
    settle();
    en_a = 1'b0; en_b = 1'b0;
    edges(2);
    set_code(2'b11);
    edges(3 * FILT);
    chk(NONE, "R5 no detection with enables low");
    en_b = 1'b1;
    edges(FILT);
    chk(NONE, "R7 low-to-high restart window");
    edges(1);
    chk(SUP, "R5 detection after enable");
  endtask

  task automatic t_async_reset();
    rst_n = 1'b0;
    #1ns;
    chk(NONE, "R11 asynchronous clear");
    edges(2);
    rst_n = 1'b1;
    set_code(2'b01);
    edges(4);
    chk(NONE, "R10 fault_any low after reset");
  endtask

  initial begin
    edges(1);
    t_reset();
    t_normal();
    t_open();
    t_first_come_clear();
    t_pattern_change();
    t_gnd();
    t_restart();
    t_no_restart();
    t_inactive();
    t_async_reset();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(TCLK * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule